// File: doc/BRIEF.md
# Descriptor DMA Run/Stop Controller

This block is the control core for one direction of a descriptor-driven packet DMA engine. Software sets a run bit and supplies the base address of a descriptor ring. The controller then tracks the process state and keeps the pointer to the current descriptor. It asks for descriptor fetches and watches the ownership flag that comes back with each one. The bus master, descriptor parsing and data movement sit in neighbouring logic. That logic returns a fetch response, and the datapath signals the start and end of each frame.

A descriptor that is still held by software puts the process into a suspended state and raises a sticky status flag. A poll pulse from software makes the controller re-check that descriptor. Clearing the run bit is treated as a request. It takes effect at a frame boundary, or at once while the process is suspended. The ring position is kept across stop and restart. A base address that software changes while the process is stopped is adopted only at the next start.

Top module: `dma_runstop_ctrl`

## Requirements
- R1: After reset, `proc_state` is 2'd0 (stopped), `cur_ptr` is 0, `fetch_req` is 0 and `buf_unavail` is 0.
- R2: While stopped, `run_en` high moves `proc_state` to 2'd1 (running) on the next cycle. On the first start ever, `cur_ptr` takes the value of `list_base`.
- R3: While running with no descriptor held and no frame in progress, `fetch_req` is 1. A `desc_valid` with `desc_owned`=1 accepts the descriptor, and `fetch_req` is 0 from the next cycle until that descriptor's frame completes.
- R4: A `desc_valid` with `desc_owned`=0 during a fetch moves `proc_state` to 2'd2 (suspended) and sets `buf_unavail` on the next cycle. `cur_ptr` stays at that descriptor.
- R5: A `frame_done` that ends a frame begun by `frame_start` on an accepted descriptor moves `cur_ptr` forward by DESC_BYTES, modulo 2^ADDR_W. If that descriptor carried `desc_last`=1, `cur_ptr` wraps to the adopted base address instead.
- R6: If `run_en` is low while a frame is in progress, the process stays running until `frame_done`. It then enters the stopped state with `cur_ptr` already advanced.
- R7: If `run_en` is low while running with no frame in progress, or while suspended, the process enters the stopped state on the next cycle and `cur_ptr` is unchanged.
- R8: A restart with `list_base` unchanged since the last adoption resumes from the saved `cur_ptr`.
- R9: A `list_base` value that differs from the adopted base is loaded into `cur_ptr` only when the process leaves the stopped state. Changes made while the process is running or suspended are not used, and a ring wrap still returns to the adopted base.
- R10: A `poll_req` pulse while suspended and with `run_en` high returns the process to running with `fetch_req` high, so that ownership is checked again.
- R11: `buf_unavail` stays at 1 until an `unavail_clr` pulse, which clears it on the next cycle. A new suspension in the same cycle as the clear pulse wins, and the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Software run bit (level) |
| list_base | input | ADDR_W | Descriptor ring base address |
| poll_req | input | 1 | Software poll pulse, re-checks ownership while suspended |
| desc_valid | input | 1 | Fetch response valid |
| desc_owned | input | 1 | Fetched descriptor belongs to the engine |
| desc_last | input | 1 | Fetched descriptor is the last one in the ring |
| frame_start | input | 1 | Datapath began a frame on the held descriptor |
| frame_done | input | 1 | Datapath finished the frame in progress |
| unavail_clr | input | 1 | Write-one-to-clear strobe for `buf_unavail` |
| cur_ptr | output | ADDR_W | Current descriptor address |
| proc_state | output | 2 | 0 stopped, 1 running, 2 suspended |
| fetch_req | output | 1 | Request to fetch the descriptor at `cur_ptr` |
| buf_unavail | output | 1 | Sticky flag: a descriptor was not available |

## Verification
The bench builds the block with ADDR_W=12 and DESC_BYTES=8. This keeps the address space small enough that a base near its top makes pointer advance overflow back to zero, which the bench checks alongside the ring wrap to the adopted base. The 8-byte step gives distinct addresses after only a few descriptors. A long random phase then drives run-bit toggles, base changes, poll pulses and ownership refusals in every state, including stop requests in the middle of a frame.

// File: rtl/dma_runstop_ctrl.sv
module dma_runstop_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [ADDR_W-1:0] list_base,
  input  logic              poll_req,
  input  logic              desc_valid,
  input  logic              desc_owned,
  input  logic              desc_last,
  input  logic              frame_start,
  input  logic              frame_done,
  input  logic              unavail_clr,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic [1:0]        proc_state,
  output logic              fetch_req,
  output logic              buf_unavail
);
  localparam logic [1:0] ST_STOP = 2'd0, ST_RUN = 2'd1, ST_SUSP = 2'd2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  logic [1:0]        st;
  logic [ADDR_W-1:0] ptr, base_q;
  logic              have_desc, in_frame, ring_end, started, unavail;

  wire adopt   = !started || (list_base != base_q);
  wire refused = (st == ST_RUN) && run_en && !have_desc && desc_valid && !desc_owned;
  wire [ADDR_W-1:0] nxt_ptr = ring_end ? base_q : ptr + STEP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_STOP;
      ptr       <= '0;
      base_q    <= '0;
      have_desc <= 1'b0;
      in_frame  <= 1'b0;
      ring_end  <= 1'b0;
      started   <= 1'b0;
    end else begin
      case (st)
        ST_STOP: if (run_en) begin
          st        <= ST_RUN;
          started   <= 1'b1;
          have_desc <= 1'b0;
          in_frame  <= 1'b0;
          if (adopt) begin
            ptr    <= list_base;
            base_q <= list_base;
          end
        end
        ST_RUN: begin
          if (in_frame) begin
            if (frame_done) begin
              ptr       <= nxt_ptr;
              have_desc <= 1'b0;
              in_frame  <= 1'b0;
              if (!run_en) st <= ST_STOP;
            end
          end else if (!run_en) begin
            st        <= ST_STOP;
            have_desc <= 1'b0;
          end else if (have_desc) begin
            if (frame_start) in_frame <= 1'b1;
          end else if (desc_valid) begin
            if (desc_owned) begin
              have_desc <= 1'b1;
              ring_end  <= desc_last;
            end else begin
              st <= ST_SUSP;
            end
          end
        end
        ST_SUSP: begin
          if (!run_en)       st <= ST_STOP;
          else if (poll_req) st <= ST_RUN;
        end
        default: st <= ST_STOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           unavail <= 1'b0;
    else if (refused)     unavail <= 1'b1;
    else if (unavail_clr) unavail <= 1'b0;
  end

  assign cur_ptr     = ptr;
  assign proc_state  = st;
  assign fetch_req   = (st == ST_RUN) && !have_desc && !in_frame;
  assign buf_unavail = unavail;
endmodule

// File: rtl/dma_runstop_ctrl_chk.sv
module dma_runstop_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic              desc_valid,
  input logic              desc_owned,
  input logic              unavail_clr,
  input logic [ADDR_W-1:0] cur_ptr,
  input logic [1:0]        proc_state,
  input logic              fetch_req,
  input logic              buf_unavail
);
  // R1
  state_legal_chk: assert property (@(posedge clk) disable iff (!rst_n) proc_state != 2'd3);
  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 2'd0 && run_en) |=> proc_state == 2'd1);
  // R3
  fetch_only_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req |-> proc_state == 2'd1);
  // R4
  refuse_suspend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && run_en && desc_valid && !desc_owned) |=> (proc_state == 2'd2 && buf_unavail));
  // R4
  susp_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proc_state == 2'd2 |=> $stable(cur_ptr));
  // R7
  susp_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 2'd2 && !run_en) |=> proc_state == 2'd0);
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_state == 2'd0 && !run_en) |=> (proc_state == 2'd0 && $stable(cur_ptr)));
  // R11
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_unavail && !unavail_clr) |=> buf_unavail);
endmodule

bind dma_runstop_ctrl dma_runstop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .desc_valid(desc_valid),
  .desc_owned(desc_owned), .unavail_clr(unavail_clr), .cur_ptr(cur_ptr),
  .proc_state(proc_state), .fetch_req(fetch_req), .buf_unavail(buf_unavail));

// File: tb/test_dma_runstop_ctrl.sv
`timescale 1ns/1ps
module test_dma_runstop_ctrl;
  localparam int AW = 12;
  localparam int DB = 8;
  localparam int MASK = (1 << AW) - 1;

  logic clk = 0, rst_n = 0;
  logic run_en = 0, poll_req = 0, desc_valid = 0, desc_owned = 0, desc_last = 0;
  logic frame_start = 0, frame_done = 0, unavail_clr = 0;
  logic [AW-1:0] list_base = '0;
  logic [AW-1:0] cur_ptr;
  logic [1:0] proc_state;
  logic fetch_req, buf_unavail;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dma_runstop_ctrl #(.ADDR_W(AW), .DESC_BYTES(DB)) i_dma_runstop_ctrl (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .list_base(list_base),
    .poll_req(poll_req), .desc_valid(desc_valid), .desc_owned(desc_owned),
    .desc_last(desc_last), .frame_start(frame_start), .frame_done(frame_done),
    .unavail_clr(unavail_clr), .cur_ptr(cur_ptr), .proc_state(proc_state),
    .fetch_req(fetch_req), .buf_unavail(buf_unavail));

  // behavioural reference: 0 idle, 1 active, 2 waiting on software
  int m_st = 0, m_ptr = 0, m_base = 0;
  bit m_seen = 0, m_hold = 0, m_busy = 0, m_wrap = 0, m_flag = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_ptr = 0; m_base = 0; m_seen = 0; m_hold = 0; m_busy = 0; m_wrap = 0; m_flag = 0;
    end else begin
      bit setf;
      setf = 0;
      if (m_st == 0) begin
        if (run_en) begin
          if (!m_seen || int'(list_base) != m_base) begin m_base = list_base; m_ptr = list_base; end
          m_seen = 1; m_st = 1; m_hold = 0; m_busy = 0;
        end
      end else if (m_st == 2) begin
        if (!run_en) m_st = 0;
        else if (poll_req) m_st = 1;
      end else if (m_busy) begin
        if (frame_done) begin
          m_ptr = m_wrap ? m_base : ((m_ptr + DB) & MASK);
          m_busy = 0; m_hold = 0;
          if (!run_en) m_st = 0;
        end
      end else if (!run_en) begin
        m_st = 0; m_hold = 0;
      end else if (m_hold) begin
        if (frame_start) m_busy = 1;
      end else if (desc_valid) begin
        if (desc_owned) begin m_hold = 1; m_wrap = desc_last; end
        else begin m_st = 2; setf = 1; end
      end
      if (setf) m_flag = 1;
      else if (unavail_clr) m_flag = 0;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R2 state", proc_state, m_st);
    chk("R5 cur_ptr", cur_ptr, m_ptr);
    chk("R3 fetch_req", fetch_req, (m_st == 1 && !m_hold && !m_busy) ? 1 : 0);
    chk("R11 buf_unavail", buf_unavail, m_flag);
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
    poll_req = 0; desc_valid = 0; frame_start = 0; frame_done = 0; unavail_clr = 0;
  endtask

  task automatic give(input bit own, input bit last);
    desc_valid = 1; desc_owned = own; desc_last = last; cyc(1);
  endtask

  task automatic frame();
    frame_start = 1; cyc(1); frame_done = 1; cyc(1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3); rst_n = 1; #1;
    chk("R1 state", proc_state, 0); chk("R1 ptr", cur_ptr, 0);
    chk("R1 fetch", fetch_req, 0); chk("R1 flag", buf_unavail, 0);

    list_base = 12'h100; run_en = 1; cyc(1);
    chk("R2 run", proc_state, 1); chk("R2 base load", cur_ptr, 12'h100);
    chk("R3 fetch", fetch_req, 1);
    give(1, 0); chk("R3 held", fetch_req, 0);
    frame(); chk("R5 advance", cur_ptr, 12'h108);
    give(1, 1); frame(); chk("R5 ring wrap", cur_ptr, 12'h100);

    give(1, 0); frame_start = 1; cyc(1); run_en = 0; cyc(3);
    chk("R6 deferred", proc_state, 1);
    frame_done = 1; cyc(1);
    chk("R6 stopped", proc_state, 0); chk("R6 ptr", cur_ptr, 12'h108);

    run_en = 1; cyc(1); chk("R8 resume", cur_ptr, 12'h108);
    run_en = 0; cyc(1); chk("R7 stop idle", proc_state, 0); chk("R7 ptr", cur_ptr, 12'h108);

    list_base = 12'h200; cyc(1); run_en = 1; cyc(1); chk("R9 adopt", cur_ptr, 12'h200);
    list_base = 12'h300; give(1, 1); frame(); chk("R9 ignored while running", cur_ptr, 12'h200);

    give(0, 0); chk("R4 suspend", proc_state, 2); chk("R4 flag", buf_unavail, 1);
    cyc(2); chk("R11 sticky", buf_unavail, 1);
    unavail_clr = 1; cyc(1); chk("R11 cleared", buf_unavail, 0);
    poll_req = 1; cyc(1); chk("R10 poll", proc_state, 1); chk("R10 refetch", fetch_req, 1);
    desc_valid = 1; desc_owned = 0; unavail_clr = 1; cyc(1);
    chk("R11 set wins", buf_unavail, 1); chk("R4 again", proc_state, 2);
    run_en = 0; cyc(1); chk("R7 stop suspended", proc_state, 0); chk("R7 ptr", cur_ptr, 12'h200);

    list_base = 12'hFF8; run_en = 1; cyc(1); chk("R9 new base", cur_ptr, 12'hFF8);
    give(1, 0); frame(); chk("R5 modulo", cur_ptr, 12'h000);

    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 4) run_en = ~run_en;
      if ($urandom_range(0, 99) < 3) list_base = AW'($urandom_range(0, 15) * 16);
      poll_req    = ($urandom_range(0, 9) == 0);
      desc_valid  = ($urandom_range(0, 2) == 0);
      desc_owned  = ($urandom_range(0, 3) != 0);
      desc_last   = ($urandom_range(0, 4) == 0);
      frame_start = ($urandom_range(0, 2) == 0);
      frame_done  = ($urandom_range(0, 3) == 0);
      unavail_clr = ($urandom_range(0, 7) == 0);
      cyc(1);
    end
    finish_run();
  end
endmodule